// File: doc/BRIEF.md
# Software Inter-Processor Command Dispatcher

This block turns a single software store into a control action aimed at one processor of a small cluster. The stored word carries a two-bit command type, a target processor number and a six-bit vector. Four commands share this one register. The first posts an interrupt carrying the vector. The second applies a power-on reset and leaves the target running. The third halts the target. The fourth lets the target run again.

For every processor the block drives three outputs: a one-cycle interrupt-post strobe, a one-cycle power-on-reset strobe and a level showing whether that processor is running. A separate output carries the vector of the most recent interrupt post. The block also checks each command. A command aimed at a processor number that is not present does nothing. A reset command whose vector is not the power-on-reset trap code is thrown away and sets an error flag that stays set. How the cores respond to these strobes and levels is outside this block.

Top module: `ipi_cmd_dispatch`

## Requirements
- R1: While reset is asserted and after it is released, `run_state` is all zeros except bit 0, which is 1. `irq_post` and `por_pulse` are zero and `reset_err` is 0.
- R2: A write with type 0 to a present processor N raises `irq_post[N]` alone in the cycle after the write, with `irq_vec` equal to the written vector. `run_state` does not change.
- R3: A write with type 1 to a present processor N whose vector equals `POR_CODE` (default 1) raises `por_pulse[N]` alone in the cycle after the write. `run_state[N]` becomes 1 in that same cycle.
- R4: A write with type 2 to a present processor N clears `run_state[N]` in the cycle after the write and raises no strobe.
- R5: A write with type 3 to a present processor N sets `run_state[N]` in the cycle after the write and raises no strobe.
- R6: A write whose processor number is at or above `NUM_CPU` changes none of the outputs (`irq_post`, `por_pulse`, `run_state`, `reset_err`), whatever its type and vector.
- R7: A type 1 write to a present processor whose vector differs from `POR_CODE` raises no strobe and leaves `run_state` unchanged. It sets `reset_err`, which then stays 1 until reset.
- R8: The type is read from bits 17:16 of the write data, the processor number from bits 12:8 and the vector from bits 5:0. All other data bits have no effect.
- R9: Each strobe lasts exactly one cycle. With no write in the following cycle, `irq_post` and `por_pulse` return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Store to the dispatch register in this cycle |
| wr_data | input | DATA_W | Stored command word |
| irq_post | output | NUM_CPU | One-cycle interrupt post strobe per processor |
| irq_vec | output | 6 | Vector of the latest interrupt post |
| por_pulse | output | NUM_CPU | One-cycle power-on-reset strobe per processor |
| run_state | output | NUM_CPU | Running (1) or halted (0) per processor |
| reset_err | output | 1 | Sticky flag for a reset command with a bad vector |

## Verification
The hardest case to reach is the interaction between the processor-number range check and the reset-vector check. A reset command with a bad vector aimed at a missing processor must leave the error flag clear, while the same command aimed at a present processor must set it. The bench sweeps every type over all 32 encodable processor numbers, with vectors that include the trap code and values next to it. It fills the unused data bits with changing junk. The sweep runs while the error flag is both clear and already set, and a second reset shows that the flag clears.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;
   localparam int TYPE_LSB = 16;
   localparam int TYPE_W   = 2;
   localparam int ID_LSB   = 8;
   localparam int ID_W     = 5;
   localparam int VEC_LSB  = 0;
   localparam int VEC_W    = 6;

   typedef enum logic [TYPE_W-1:0] {
      CMD_IRQ    = 2'd0,
      CMD_POR    = 2'd1,
      CMD_HALT   = 2'd2,
      CMD_RESUME = 2'd3
   } cmd_e;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
   import ipi_cmd_pkg::*;
#(
   parameter int NUM_CPU  = 8,
   parameter int DATA_W   = 32,
   parameter int POR_CODE = 1
) (
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output cmd_e              cmd,
   output logic [VEC_W-1:0]  vec,
   output logic [NUM_CPU-1:0] hit,
   output logic              por_ok,
   output logic              bad_reset
);
   logic [ID_W-1:0] tgt_id;
   logic            in_range;

   assign cmd    = cmd_e'(wr_data[TYPE_LSB +: TYPE_W]);
   assign tgt_id = wr_data[ID_LSB +: ID_W];
   assign vec    = wr_data[VEC_LSB +: VEC_W];

   assign in_range  = int'(tgt_id) < NUM_CPU;
   assign por_ok    = vec == VEC_W'(POR_CODE);
   assign bad_reset = wr_en && in_range && (cmd == CMD_POR) && !por_ok;

   for (genvar i = 0; i < NUM_CPU; i++) begin : g_hit
      assign hit[i] = wr_en && (tgt_id == ID_W'(i));
   end
endmodule

// File: rtl/ipi_cpu_slot.sv
module ipi_cpu_slot
   import ipi_cmd_pkg::*;
#(
   parameter bit RUN_AT_RESET = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  cmd_e cmd,
   input  logic por_ok,
   output logic post,
   output logic por,
   output logic run
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         post <= 1'b0;
         por  <= 1'b0;
         run  <= RUN_AT_RESET;
      end else begin
         post <= hit && (cmd == CMD_IRQ);
         por  <= hit && (cmd == CMD_POR) && por_ok;
         if (hit) begin
            unique case (cmd)
               CMD_POR:    if (por_ok) run <= 1'b1;
               CMD_HALT:   run <= 1'b0;
               CMD_RESUME: run <= 1'b1;
               default:    run <= run;
            endcase
         end
      end
   end
endmodule

// File: rtl/ipi_err_flag.sv
module ipi_err_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
   end
endmodule

// File: rtl/ipi_cmd_dispatch.sv
module ipi_cmd_dispatch
   import ipi_cmd_pkg::*;
#(
   parameter int NUM_CPU  = 8,
   parameter int DATA_W   = 32,
   parameter int POR_CODE = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [NUM_CPU-1:0] irq_post,
   output logic [VEC_W-1:0]   irq_vec,
   output logic [NUM_CPU-1:0] por_pulse,
   output logic [NUM_CPU-1:0] run_state,
   output logic               reset_err
);
   localparam int MAX_CPU = 1 << ID_W;
   localparam int MIN_W   = TYPE_LSB + TYPE_W;

   if (NUM_CPU < 1 || NUM_CPU > MAX_CPU) begin : g_bad_cpu
      $error("NUM_CPU must lie in 1..%0d", MAX_CPU);
   end
   if (DATA_W < MIN_W) begin : g_bad_w
      $error("DATA_W must be at least %0d", MIN_W);
   end
   if (POR_CODE < 0 || POR_CODE >= (1 << VEC_W)) begin : g_bad_por
      $error("POR_CODE does not fit the vector field");
   end

   cmd_e               cmd;
   logic [VEC_W-1:0]   vec;
   logic [NUM_CPU-1:0] hit;
   logic               por_ok;
   logic               bad_reset;

   ipi_cmd_decode #(
      .NUM_CPU (NUM_CPU),
      .DATA_W  (DATA_W),
      .POR_CODE(POR_CODE)
   ) u_dec (
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .cmd      (cmd),
      .vec      (vec),
      .hit      (hit),
      .por_ok   (por_ok),
      .bad_reset(bad_reset)
   );

   for (genvar i = 0; i < NUM_CPU; i++) begin : g_slot
      ipi_cpu_slot #(.RUN_AT_RESET(i == 0)) u_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .hit   (hit[i]),
         .cmd   (cmd),
         .por_ok(por_ok),
         .post  (irq_post[i]),
         .por   (por_pulse[i]),
         .run   (run_state[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq_vec <= '0;
      else if ((|hit) && cmd == CMD_IRQ)
         irq_vec <= vec;
   end

   ipi_err_flag u_err (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (bad_reset),
      .flag (reset_err)
   );
endmodule

// File: rtl/ipi_cmd_dispatch_chk.sv
module ipi_cmd_dispatch_chk
   import ipi_cmd_pkg::*;
#(
   parameter int NUM_CPU  = 8,
   parameter int DATA_W   = 32,
   parameter int POR_CODE = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [DATA_W-1:0]  wr_data,
   input logic [NUM_CPU-1:0] irq_post,
   input logic [VEC_W-1:0]   irq_vec,
   input logic [NUM_CPU-1:0] por_pulse,
   input logic [NUM_CPU-1:0] run_state,
   input logic               reset_err
);
   logic [ID_W-1:0]   c_id;
   logic [TYPE_W-1:0] c_type;
   logic [VEC_W-1:0]  c_vec;
   assign c_id   = wr_data[ID_LSB +: ID_W];
   assign c_type = wr_data[TYPE_LSB +: TYPE_W];
   assign c_vec  = wr_data[VEC_LSB +: VEC_W];

   a_r2_post_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_post));

   a_r3_por_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(por_pulse));

   a_r3_por_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (por_pulse & ~run_state) == '0);

   a_r6_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(c_id) >= NUM_CPU) |=>
         (irq_post == '0 && por_pulse == '0 && $stable(run_state) && $stable(reset_err)));

   a_r7_bad_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(c_id) < NUM_CPU && c_type == 2'd1 && c_vec != VEC_W'(POR_CODE)) |=>
         (reset_err && por_pulse == '0 && $stable(run_state)));

   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reset_err) |-> reset_err);

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (irq_post == '0 && por_pulse == '0));
endmodule

bind ipi_cmd_dispatch ipi_cmd_dispatch_chk #(
   .NUM_CPU (NUM_CPU),
   .DATA_W  (DATA_W),
   .POR_CODE(POR_CODE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .irq_post (irq_post),
   .irq_vec  (irq_vec),
   .por_pulse(por_pulse),
   .run_state(run_state),
   .reset_err(reset_err)
);

// File: tb/ipi_cmd_dispatch_tb.sv
module ipi_cmd_dispatch_tb;
   localparam int N   = 8;
   localparam int DW  = 32;
   localparam int POR = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [N-1:0]  irq_post, por_pulse, run_state;
   logic [5:0]    irq_vec;
   logic          reset_err;

   int checks = 0;
   int fails  = 0;

   logic [N-1:0] m_run;
   logic         m_err;

   ipi_cmd_dispatch #(.NUM_CPU(N), .DATA_W(DW), .POR_CODE(POR)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .irq_post(irq_post), .irq_vec(irq_vec), .por_pulse(por_pulse),
      .run_state(run_state), .reset_err(reset_err)
   );

   always #10 clk = ~clk;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wr_en = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 run", 32'(run_state), 32'h1);
      chk("R1 strobes", 32'({irq_post, por_pulse}), 32'h0);
      chk("R1 err", 32'(reset_err), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 run after release", 32'(run_state), 32'h1);
      m_run = N'(1);
      m_err = 1'b0;
   endtask

   task automatic send(int typ, int id, int vec, int junk);
      logic [N-1:0] e_post, e_por;
      logic [DW-1:0] w;
      e_post = '0;
      e_por  = '0;
      @(negedge clk);
      chk("R9 quiet", 32'({irq_post, por_pulse}), 32'h0);
      w = DW'(junk) & ~DW'(32'h0003_1F3F);
      w = w | (DW'(typ) << 16) | (DW'(id) << 8) | DW'(vec);
      wr_data = w;
      wr_en   = 1'b1;
      if (id < N) begin
         case (typ)
            0: e_post[id] = 1'b1;
            1: if (vec == POR) begin e_por[id] = 1'b1; m_run[id] = 1'b1; end
               else m_err = 1'b1;
            2: m_run[id] = 1'b0;
            default: m_run[id] = 1'b1;
         endcase
      end
      @(negedge clk);
      wr_en = 1'b0;
      chk((typ == 0) ? "R2 post" : (id >= N) ? "R6 post" : "R8 post",
          32'(irq_post), 32'(e_post));
      chk((typ == 1) ? ((vec == POR) ? "R3 por" : "R7 por") : "R6 por",
          32'(por_pulse), 32'(e_por));
      chk((typ == 2) ? "R4 run" : (typ == 3) ? "R5 run" : "R6 run",
          32'(run_state), 32'(m_run));
      chk((typ == 1) ? "R7 err" : "R6 err", 32'(reset_err), 32'(m_err));
      if (e_post != '0) chk("R2 vec", 32'(irq_vec), 32'(vec));
   endtask

   initial begin
      int vecs [4] = '{0, 1, 2, 63};
      do_reset();
      for (int pass = 0; pass < 2; pass++) begin
         for (int t = 0; t < 4; t++) begin
            for (int id = 0; id < 32; id++) begin
               for (int v = 0; v < 4; v++) begin
                  send(t, id, vecs[v], (id * 977 + v * 12345 + pass * 31) ^ 32'hA5C3_9E61);
               end
            end
         end
      end
      send(2, 5, 0, 0);
      send(1, 5, POR, 32'hFFFF_FFFF);
      send(1, 31, 7, 0);
      @(negedge clk);
      chk("R9 strobe ends", 32'({irq_post, por_pulse}), 32'h0);
      do_reset();
      chk("R7 err cleared by reset", 32'(reset_err), 32'h0);
      send(1, 31, 9, 0);
      send(1, 8, 9, 0);
      send(1, 7, 9, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule